// File: doc/BRIEF.md
# Inbound Address Window Decoder

The block sorts inbound memory addresses into a small set of programmable windows. Each window has three registers. The control register holds the window size, an attribute byte, a target identifier and an enable. The base register holds the window's start address. The remap register gives an optional replacement base. A single enclosing aperture, modelled on a prefetchable 64-bit memory BAR, must match before any window is considered. Its size is never programmed: the hardware derives it from the sum of the enabled window sizes, rounded up to a power of two.

Software reaches the registers through a simple word-addressed register bus. Writes take effect on the next clock edge and reads are combinational. A lookup is purely combinational. The caller presents an address with a valid strobe and, in the same cycle, receives a hit or a decode error, together with the winning window's index, target, attribute and the translated address.

Top module: `inb_win_decoder`

## Requirements
- R1: After reset, every register reads zero except the aperture low register, which reads 0x0000000C. Any valid lookup after reset reports a decode error.
- R2: Registers are addressed by word index. Window n has its control register at index 4n, its base at 4n+1 and its remap at 4n+2. Index 4n+3 is unused, the aperture control register is at 24 and the aperture low register at 25. The control register keeps bits 31:16 (size minus one, in 64 KB units), 15:8 (attribute), 7:4 (target) and 0 (enable); bits 3:1 read zero. The base register keeps bits 31:16. The remap register keeps bits 31:16 and bit 0 (remap enable). Unmapped indices read zero and writes to them have no effect.
- R3: A window matches when its enable is set and (address AND NOT {size field, 16'hFFFF}) equals its base register.
- R4: When several windows match, the lowest index wins.
- R5: On a hit with remap enable set, the output address is the remap base OR the address bits inside the window span. With remap enable clear, the output address equals the input address.
- R6: On a hit, the target and attribute outputs carry the winning window's fields, and the window output carries its index.
- R7: A hit also requires the aperture enable (aperture control bit 0) to be set, and requires (address AND NOT span) to equal (aperture base AND NOT span). Here span is {aperture size field, 16'hFFFF} and the aperture base is bits 31:16 of the aperture low register.
- R8: Aperture control bits 31:16 read the hardware-computed size minus one, in 64 KB units. The size is the sum of the enabled window sizes, rounded up to a power of two; an exact power of two is kept, and the field saturates at 0xFFFF. Writes change only bit 0.
- R9: The aperture low register stores bits 31:16 and always reads 0xC in bits 3:0.
- R10: Writing zero to a window control register disables that window, so lookups fall through to the next matching window or to a decode error.
- R11: A valid lookup with no hit raises the decode error. While the lookup valid is low, both the hit and the decode error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| lkpValid | input | 1 | Lookup request valid |
| lkpAddr | input | 32 | Lookup address |
| lkpHit | output | 1 | Lookup hit a window |
| lkpErr | output | 1 | Lookup decode error |
| lkpWin | output | 3 | Winning window index |
| lkpTarget | output | 4 | Winning window target ID |
| lkpAttr | output | 8 | Winning window attribute |
| lkpAddrOut | output | 32 | Translated address |

## Verification
The register state feeds the lookup path with no intervening pipeline stage. A corrupted control, base or remap field therefore shows up at the lookup outputs in the cycle after the bad write. It appears as a wrong target or attribute, a shifted output address, or a hit where a decode error was due.

The aperture size logic is checked the same way. A wrong sum or rounding changes the aperture control readback at once, and it also moves the aperture boundary, so an address just outside the intended aperture either hits or errors in the very next lookup. The scenarios place addresses on both sides of the window and aperture edges to expose these faults.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;

  localparam int WIN_IDX_MAX = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_WCTRL,
    SEL_WBASE,
    SEL_WREMAP,
    SEL_APCTRL,
    SEL_APLOW
  } regSel_e;

  typedef struct packed {
    logic                   wrEn;
    regSel_e                sel;
    logic [WIN_IDX_MAX-1:0] winIdx;
  } regStrobe_t;

  localparam logic [31:0] CTRL_KEEP  = 32'hFFFF_FFF1;
  localparam logic [31:0] BASE_KEEP  = 32'hFFFF_0000;
  localparam logic [31:0] REMAP_KEEP = 32'hFFFF_0001;
  localparam logic [31:0] BAR_FLAGS  = 32'h0000_000C;

endpackage

// File: rtl/inb_win_ctrl.sv
module inb_win_ctrl
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int REG_AW  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strb
);

  localparam logic [REG_AW-1:0] WIN_END  = REG_AW'(NUM_WIN * 4);
  localparam logic [REG_AW-1:0] APC_IDX  = REG_AW'(NUM_WIN * 4);
  localparam logic [REG_AW-1:0] APL_IDX  = REG_AW'(NUM_WIN * 4 + 1);

  always_comb begin
    strb.sel    = SEL_NONE;
    strb.winIdx = WIN_IDX_MAX'(regAddr >> 2);
    if (regAddr < WIN_END) begin
      case (regAddr[1:0])
        2'd0:    strb.sel = SEL_WCTRL;
        2'd1:    strb.sel = SEL_WBASE;
        2'd2:    strb.sel = SEL_WREMAP;
        default: strb.sel = SEL_NONE;
      endcase
    end else if (regAddr == APC_IDX) begin
      strb.sel = SEL_APCTRL;
    end else if (regAddr == APL_IDX) begin
      strb.sel = SEL_APLOW;
    end
    strb.wrEn = regWe && (strb.sel != SEL_NONE);
  end

  AST_WR_DECODED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (strb.sel != SEL_NONE && regWe)); // R2

  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_WCTRL || strb.sel == SEL_WBASE || strb.sel == SEL_WREMAP)
      |-> (int'(strb.winIdx) < NUM_WIN)); // R2

endmodule

// File: rtl/inb_win_dpath.sv
module inb_win_dpath
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN   = 6,
  parameter int WIN_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 lkpValid,
  input  logic [31:0]          lkpAddr,
  output logic                 lkpHit,
  output logic                 lkpErr,
  output logic [WIN_IDX_W-1:0] lkpWin,
  output logic [3:0]           lkpTarget,
  output logic [7:0]           lkpAttr,
  output logic [31:0]          lkpAddrOut
);

  localparam int SUM_W = 18 + $clog2(NUM_WIN);

  logic [31:0] winCtrl  [NUM_WIN];
  logic [31:0] winBase  [NUM_WIN];
  logic [31:0] winRemap [NUM_WIN];
  logic [31:0] winSpan  [NUM_WIN];
  logic [NUM_WIN-1:0] winMatch;
  logic        apEn;
  logic [31:0] apLow;

  // Per-window register storage and match
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic selHere;
    assign selHere = strb.wrEn && (strb.winIdx == WIN_IDX_MAX'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        winCtrl[i]  <= '0;
        winBase[i]  <= '0;
        winRemap[i] <= '0;
      end else if (selHere) begin
        if (strb.sel == SEL_WCTRL)  winCtrl[i]  <= regWdata & CTRL_KEEP;
        if (strb.sel == SEL_WBASE)  winBase[i]  <= regWdata & BASE_KEEP;
        if (strb.sel == SEL_WREMAP) winRemap[i] <= regWdata & REMAP_KEEP;
      end
    end

    assign winSpan[i]  = {winCtrl[i][31:16], 16'hFFFF};
    assign winMatch[i] = winCtrl[i][0] && ((lkpAddr & ~winSpan[i]) == winBase[i]);
  end

  // Aperture registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      apEn  <= 1'b0;
      apLow <= '0;
    end else if (strb.wrEn) begin
      if (strb.sel == SEL_APCTRL) apEn  <= regWdata[0];
      if (strb.sel == SEL_APLOW)  apLow <= regWdata & BASE_KEEP;
    end
  end

  // Aperture size: sum of enabled sizes, rounded up to a power of two
  logic [SUM_W-1:0] sizeSum;
  logic [SUM_W-1:0] smear;
  logic [SUM_W-1:0] roundUp;
  logic [15:0]      apField;

  always_comb begin
    sizeSum = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (winCtrl[i][0]) sizeSum = sizeSum + SUM_W'(winCtrl[i][31:16]) + SUM_W'(1);
    end
    smear = sizeSum - SUM_W'(1);
    for (int s = 1; s < SUM_W; s = s * 2) smear = smear | (smear >> s);
    roundUp = (sizeSum == '0) ? SUM_W'(1) : smear + SUM_W'(1);
    apField = (roundUp > SUM_W'(65536)) ? 16'hFFFF : 16'(roundUp - SUM_W'(1));
  end

  logic [31:0] apSpan;
  logic        apHit;
  assign apSpan = {apField, 16'hFFFF};
  assign apHit  = apEn && ((lkpAddr & ~apSpan) == (apLow & ~apSpan));

  // Lowest index wins
  logic                 found;
  logic [WIN_IDX_W-1:0] selWin;
  always_comb begin
    found  = 1'b0;
    selWin = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winMatch[i]) begin
        found  = 1'b1;
        selWin = WIN_IDX_W'(i);
      end
    end
  end

  always_comb begin
    lkpHit     = lkpValid && apHit && found;
    lkpErr     = lkpValid && !lkpHit;
    lkpWin     = '0;
    lkpTarget  = '0;
    lkpAttr    = '0;
    lkpAddrOut = '0;
    if (lkpHit) begin
      lkpWin    = selWin;
      lkpTarget = winCtrl[selWin][7:4];
      lkpAttr   = winCtrl[selWin][15:8];
      if (winRemap[selWin][0])
        lkpAddrOut = {winRemap[selWin][31:16], 16'h0000} | (lkpAddr & winSpan[selWin]);
      else
        lkpAddrOut = lkpAddr;
    end
  end

  // Register read mux
  always_comb begin
    case (strb.sel)
      SEL_WCTRL:  regRdata = winCtrl[strb.winIdx[WIN_IDX_W-1:0]];
      SEL_WBASE:  regRdata = winBase[strb.winIdx[WIN_IDX_W-1:0]];
      SEL_WREMAP: regRdata = winRemap[strb.winIdx[WIN_IDX_W-1:0]];
      SEL_APCTRL: regRdata = {apField, 15'h0, apEn};
      SEL_APLOW:  regRdata = apLow | BAR_FLAGS;
      default:    regRdata = '0;
    endcase
  end

  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    lkpHit |-> (winMatch[lkpWin] &&
               ((winMatch & ((NUM_WIN'(1) << lkpWin) - NUM_WIN'(1))) == '0))); // R4

  AST_HIT_NEEDS_AP: assert property (@(posedge clk) disable iff (!rstN)
    lkpHit |-> (apEn && lkpValid)); // R7

  AST_LOW_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    lkpHit |-> (lkpAddrOut[15:0] == lkpAddr[15:0])); // R5

  AST_APSIZE_POW2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(17'({1'b0, apField}) + 17'd1)); // R8

  AST_CTRL0_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.sel == SEL_WCTRL && strb.winIdx == '0)
      |=> (winCtrl[0] == ($past(regWdata) & CTRL_KEEP))); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lkpValid |-> (!lkpHit && !lkpErr)); // R11

endmodule

// File: rtl/inb_win_decoder.sv
module inb_win_decoder
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN   = 6,
  parameter int REG_AW    = $clog2(NUM_WIN * 4 + 2),
  parameter int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 lkpValid,
  input  logic [31:0]          lkpAddr,
  output logic                 lkpHit,
  output logic                 lkpErr,
  output logic [WIN_IDX_W-1:0] lkpWin,
  output logic [3:0]           lkpTarget,
  output logic [7:0]           lkpAttr,
  output logic [31:0]          lkpAddrOut
);

  regStrobe_t strb;

  inb_win_ctrl #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .strb(strb)
  );

  inb_win_dpath #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .regRdata(regRdata),
    .lkpValid(lkpValid), .lkpAddr(lkpAddr), .lkpHit(lkpHit), .lkpErr(lkpErr),
    .lkpWin(lkpWin), .lkpTarget(lkpTarget), .lkpAttr(lkpAttr), .lkpAddrOut(lkpAddrOut)
  );

endmodule

// File: tb/tb_inb_win_decoder.sv
`timescale 1ns/1ps
module tb_inb_win_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        lkpValid = 1'b0;
  logic [31:0] lkpAddr = '0;
  logic        lkpHit, lkpErr;
  logic [2:0]  lkpWin;
  logic [3:0]  lkpTarget;
  logic [7:0]  lkpAttr;
  logic [31:0] lkpAddrOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inb_win_decoder dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .lkpValid(lkpValid), .lkpAddr(lkpAddr), .lkpHit(lkpHit),
    .lkpErr(lkpErr), .lkpWin(lkpWin), .lkpTarget(lkpTarget), .lkpAttr(lkpAttr),
    .lkpAddrOut(lkpAddrOut)
  );

  localparam logic [4:0] AP_CTRL = 5'd24;
  localparam logic [4:0] AP_LOW  = 5'd25;

  function automatic logic [4:0] wc(int n); return 5'(4 * n); endfunction
  function automatic logic [4:0] wb(int n); return 5'(4 * n + 1); endfunction
  function automatic logic [4:0] wr(int n); return 5'(4 * n + 2); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regCheck(string tag, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic lookHit(string tag, logic [31:0] a, int win, logic [3:0] tgt,
                         logic [7:0] attr, logic [31:0] outAddr);
    @(negedge clk);
    lkpValid = 1'b1; lkpAddr = a;
    #1;
    chk({tag, " hit"}, 32'(lkpHit), 32'd1);
    chk({tag, " err"}, 32'(lkpErr), 32'd0);
    chk({tag, " win"}, 32'(lkpWin), 32'(win));
    chk({tag, " tgt"}, 32'(lkpTarget), 32'(tgt));
    chk({tag, " attr"}, 32'(lkpAttr), 32'(attr));
    chk({tag, " addr"}, lkpAddrOut, outAddr);
    lkpValid = 1'b0;
  endtask

  task automatic lookErr(string tag, logic [31:0] a);
    @(negedge clk);
    lkpValid = 1'b1; lkpAddr = a;
    #1;
    chk({tag, " hit"}, 32'(lkpHit), 32'd0);
    chk({tag, " err"}, 32'(lkpErr), 32'd1);
    lkpValid = 1'b0;
  endtask

  task automatic testReset();
    regCheck("R1 ctrl0", wc(0), 32'h0);
    regCheck("R1 base5", wb(5), 32'h0);
    regCheck("R1 apctrl", AP_CTRL, 32'h0);
    regCheck("R1 aplow", AP_LOW, 32'h0000_000C);
    lookErr("R1 lookup", 32'h0000_0000);
  endtask

  task automatic testFields();
    regWrite(wc(1), 32'hFFFF_FFFF);
    regCheck("R2 ctrl mask", wc(1), 32'hFFFF_FFF1);
    regWrite(wb(1), 32'hFFFF_FFFF);
    regCheck("R2 base mask", wb(1), 32'hFFFF_0000);
    regWrite(wr(1), 32'hFFFF_FFFF);
    regCheck("R2 remap mask", wr(1), 32'hFFFF_0001);
    regWrite(5'd3, 32'hFFFF_FFFF);
    regCheck("R2 unused idx3", 5'd3, 32'h0);
    regWrite(5'd30, 32'hFFFF_FFFF);
    regCheck("R2 unmapped 30", 5'd30, 32'h0);
    regCheck("R2 ctrl0 untouched", wc(0), 32'h0);
    regWrite(wc(1), 32'h0);
    regWrite(wb(1), 32'h0);
    regWrite(wr(1), 32'h0);
    regCheck("R10 ctrl1 cleared", wc(1), 32'h0);
  endtask

  task automatic testApertureSize();
    regWrite(wb(0), 32'h4000_0000);
    regWrite(wc(0), 32'h000F_3E11);
    regCheck("R8 exact pow2", AP_CTRL, 32'h000F_0000);
    regWrite(wb(1), 32'h4100_0000);
    regWrite(wr(1), 32'h8000_0001);
    regWrite(wc(1), 32'h00FF_5A21);
    regCheck("R8 round up", AP_CTRL, 32'h01FF_0000);
    regWrite(AP_CTRL, 32'hFFFF_FFFF);
    regCheck("R8 only enable writable", AP_CTRL, 32'h01FF_0001);
    regWrite(AP_LOW, 32'h4000_FFFF);
    regCheck("R9 aplow flags", AP_LOW, 32'h4000_000C);
  endtask

  task automatic testLookups();
    lookHit("R3 R6 win0", 32'h4001_2345, 0, 4'h1, 8'h3E, 32'h4001_2345);
    lookHit("R5 remap win1", 32'h4123_4567, 1, 4'h2, 8'h5A, 32'h8023_4567);
    lookErr("R11 gap", 32'h4010_0000);
    regWrite(wb(2), 32'h6000_0000);
    regWrite(wc(2), 32'h0000_0031);
    lookErr("R7 outside aperture", 32'h6000_1000);
    regWrite(AP_CTRL, 32'h0);
    lookErr("R7 aperture off", 32'h4001_0000);
    regWrite(AP_CTRL, 32'h1);
    @(negedge clk);
    lkpValid = 1'b0; lkpAddr = 32'h4001_0000;
    #1;
    chk("R11 idle hit", 32'(lkpHit), 32'd0);
    chk("R11 idle err", 32'(lkpErr), 32'd0);
  endtask

  task automatic testPriority();
    regWrite(wb(3), 32'h4000_0000);
    regWrite(wc(3), 32'h01FF_7741);
    regCheck("R8 grow", AP_CTRL, 32'h03FF_0001);
    lookHit("R4 win0 over win3", 32'h4001_0000, 0, 4'h1, 8'h3E, 32'h4001_0000);
    lookHit("R4 win1 over win3", 32'h4180_0000, 1, 4'h2, 8'h5A, 32'h8080_0000);
    lookHit("R4 win3 alone", 32'h4080_0000, 3, 4'h4, 8'h77, 32'h4080_0000);
    regWrite(wc(0), 32'h0);
    lookHit("R10 win0 off", 32'h4001_0000, 3, 4'h4, 8'h77, 32'h4001_0000);
  endtask

  task automatic testSaturate();
    regWrite(wc(4), 32'hFFFF_0051);
    regWrite(wc(5), 32'hFFFF_0061);
    regCheck("R8 saturate", AP_CTRL, 32'hFFFF_0001);
    lookHit("R4 win3 over win4", 32'h4080_0000, 3, 4'h4, 8'h77, 32'h4080_0000);
    lookHit("R3 win4 full span", 32'h9000_0000, 4, 4'h5, 8'h00, 32'h9000_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testApertureSize();
    testLookups();
    testPriority();
    testSaturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule